// File: doc/BRIEF.md
# Terminated Recursive Systematic Convolutional Encoder

This block is the encoder of a rate one-half recursive systematic convolutional code, built for a turbo or soft-output decoder test system. For every step it emits two bits: the systematic bit and a parity bit. The parity bit comes from a shift register whose input is the data bit combined with a feedback sum. The default code has 16 states, with feedback polynomial 37 and output polynomial 21 in octal. A static mode input instead selects a 4-state code that uses only the first two register stages.

A block always lasts `BLK_LEN` coded steps. At step 0 the register is taken as all-zero and the configuration inputs are captured. The first `BLK_LEN - m` steps each consume one information bit through a valid/ready handshake, where m is 4 in 16-state mode and 2 in 4-state mode. The last m steps take no input. On those steps the encoder drives the register input with its own feedback sum, so zeros shift in and the trellis finishes in state zero. The tail inputs appear on the systematic output. Markers flag the first and the last step of each block. A check flag reports a register that is not zero after the last tail step.

Top module: `rsc_term_enc`

## Requirements
- R1: While reset is low and in the first cycle after it, `out_valid` is low and `in_ready` is high. The first step after reset opens a new block.
- R2: The register stages are s1 (newest) to s4 (oldest), and bit i of each tap input belongs to stage i+1. The feedback bit is a = u XOR the XOR of (state AND `cfg_fb_taps`). Parity is a XOR the XOR of (state AND `cfg_ff_taps`). The new state shifts a into s1. With taps 4'b1111 and 4'b1000 this is the 37/21 code.
- R3: Each accepted bit (`in_valid` and `in_ready` both high at a clock edge) gives `out_valid` high in the next cycle, with `out_sys` equal to that bit.
- R4: A block has exactly `BLK_LEN` steps. `out_first` marks step 0 and `out_last` marks step `BLK_LEN-1`. The register is taken as zero at step 0.
- R5: The last m steps of a block run on consecutive cycles with `in_ready` low. For each of them the tail input u is the XOR of (state AND feedback taps) and appears on `out_sys`. The register ends at zero and `term_err` stays low.
- R6: When `cfg_short` is 1, only stages s1 and s2 exist, tap bits 3:2 are ignored and m = 2. When it is 0, m = 4.
- R7: The configuration inputs are captured at step 0 of a block. Changes during the rest of the block have no effect on the outputs.
- R8: A cycle with `in_valid` low outside the tail makes no step: `out_valid` is low next cycle and the state is kept.
- R9: `term_err` is high only together with `out_last`, and only if the register would not be zero after that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_short | input | 1 | 1 selects the 4-state code |
| cfg_fb_taps | input | 4 | Feedback taps on s1..s4 |
| cfg_ff_taps | input | 4 | Parity taps on s1..s4 |
| in_valid | input | 1 | Information bit present |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | High outside the tail steps |
| out_valid | output | 1 | Coded pair present |
| out_sys | output | 1 | Systematic bit |
| out_par | output | 1 | Parity bit |
| out_first | output | 1 | Step 0 of the block |
| out_last | output | 1 | Final tail step of the block |
| term_err | output | 1 | Register not zero after the final step |

## Verification
Every coded pair is registered, so it appears exactly one cycle after the clock edge that accepted its bit or issued its tail step. `in_ready` is combinational from the step counter and holds for the whole cycle. The bench drives inputs on the falling edge and runs a bench-side shift-register model for that edge's step. It compares the DUT outputs on the next falling edge, after the single register stage. It checks `in_ready` against the model just after driving. Random valid gaps, mid-block configuration changes and both code sizes exercise the tail and capture timing.

// File: rtl/rsc_pkg.sv
// Shared types for the terminated recursive systematic encoder.
// Assumes a maximum register memory of four stages (16 states).
package rsc_pkg;
    localparam int RSC_MAX_MEM = 4;

    // Code configuration: size select plus tap vectors, bit i = stage i+1.
    typedef struct packed {
        logic                   short_mode;
        logic [RSC_MAX_MEM-1:0] fb_taps;
        logic [RSC_MAX_MEM-1:0] ff_taps;
    } rsc_cfg_t;

    // Result of one trellis step.
    typedef struct packed {
        logic sys;
        logic par;
        logic fb;
    } rsc_step_t;
endpackage

// File: rtl/rsc_step.sv
// Combinational trellis step: from the current state, configuration and
// input bit, forms the feedback bit, systematic and parity outputs and
// the next state. In tail steps the input is replaced by the feedback sum
// so that a zero shifts in. Assumes the state beyond the active memory is zero.
module rsc_step
    import rsc_pkg::*;
#(
    parameter int MEM       = RSC_MAX_MEM,
    parameter int SHORT_MEM = 2
) (
    input  logic [MEM-1:0] state,
    input  rsc_cfg_t       cfg,
    input  logic           in_bit,
    input  logic           tail,
    output rsc_step_t      res,
    output logic [MEM-1:0] next_state
);
    logic [MEM-1:0] stage_mask;
    logic [MEM-1:0] fb_used;
    logic [MEM-1:0] ff_used;
    logic           fb_sum;
    logic           u;

    // Mask of stages present in the selected code size.
    generate
        for (genvar i = 0; i < MEM; i++) begin : g_mask
            if (i < SHORT_MEM) begin : g_always
                assign stage_mask[i] = 1'b1;
            end else begin : g_long_only
                assign stage_mask[i] = ~cfg.short_mode;
            end
        end
    endgenerate

    // Feedback sum, tail input selection and parity.
    always_comb begin
        fb_used = cfg.fb_taps & stage_mask;
        ff_used = cfg.ff_taps & stage_mask;
        fb_sum  = ^(state & fb_used);
        u       = tail ? fb_sum : in_bit;
        res.sys = u;
        res.fb  = u ^ fb_sum;
        res.par = res.fb ^ (^(state & ff_used));
    end

    // Shift register: feedback into s1, each stage takes its neighbour.
    generate
        for (genvar i = 0; i < MEM; i++) begin : g_shift
            if (i == 0) begin : g_head
                assign next_state[i] = stage_mask[i] & res.fb;
            end else begin : g_body
                assign next_state[i] = stage_mask[i] & state[i-1];
            end
        end
    endgenerate
endmodule

// File: rtl/rsc_blk_ctrl.sv
// Block sequencer: counts coded steps in a block, captures configuration
// at step 0, decides when tail steps run and when input is accepted.
// Assumes BLK_LEN exceeds the register memory.
module rsc_blk_ctrl
    import rsc_pkg::*;
#(
    parameter int MEM       = RSC_MAX_MEM,
    parameter int SHORT_MEM = 2,
    parameter int BLK_LEN   = 4096
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  rsc_cfg_t cfg_live,
    output rsc_cfg_t cfg_eff,
    output logic     fire,
    output logic     first,
    output logic     last,
    output logic     tail,
    output logic     in_ready
);
    localparam int             CNT_W      = $clog2(BLK_LEN);
    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(BLK_LEN - 1);
    localparam logic [CNT_W-1:0] TAIL_LONG = CNT_W'(BLK_LEN - MEM);
    localparam logic [CNT_W-1:0] TAIL_SHRT = CNT_W'(BLK_LEN - SHORT_MEM);

    logic [CNT_W-1:0] cnt;
    rsc_cfg_t         cfg_q;
    logic [CNT_W-1:0] tail_start;

    // Decode the phase of the current step.
    always_comb begin
        tail_start = cfg_q.short_mode ? TAIL_SHRT : TAIL_LONG;
        first      = (cnt == '0);
        tail       = !first && (cnt >= tail_start);
        last       = (cnt == LAST_IDX);
        in_ready   = !tail;
        fire       = tail || in_valid;
        cfg_eff    = first ? cfg_live : cfg_q;
    end

    // Step counter, wraps at the end of the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (fire) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    // Capture the configuration on the first step of a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (fire && first) begin
            cfg_q <= cfg_live;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX); // R4
    AST_TAIL_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tail && !last) |=> tail); // R5
endmodule

// File: rtl/rsc_term_enc.sv
// Top of the terminated recursive systematic convolutional encoder.
// Accepts one bit per handshake, adds the tail steps at the end of each
// block and registers the coded pair with block markers.
// Assumes the configuration inputs are quasi-static (captured at step 0).
module rsc_term_enc
    import rsc_pkg::*;
#(
    parameter int BLK_LEN   = 4096,
    parameter int SHORT_MEM = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_short,
    input  logic [RSC_MAX_MEM-1:0] cfg_fb_taps,
    input  logic [RSC_MAX_MEM-1:0] cfg_ff_taps,
    input  logic                   in_valid,
    input  logic                   in_bit,
    output logic                   in_ready,
    output logic                   out_valid,
    output logic                   out_sys,
    output logic                   out_par,
    output logic                   out_first,
    output logic                   out_last,
    output logic                   term_err
);
    localparam int MEM = RSC_MAX_MEM;

    rsc_cfg_t       cfg_live;
    rsc_cfg_t       cfg_eff;
    logic           fire;
    logic           first;
    logic           last;
    logic           tail;
    logic [MEM-1:0] state_q;
    logic [MEM-1:0] state_eff;
    logic [MEM-1:0] state_nxt;
    rsc_step_t      res;

    // Pack the configuration pins.
    always_comb begin
        cfg_live.short_mode = cfg_short;
        cfg_live.fb_taps    = cfg_fb_taps;
        cfg_live.ff_taps    = cfg_ff_taps;
        state_eff           = first ? '0 : state_q;
    end

    rsc_blk_ctrl #(
        .MEM       (MEM),
        .SHORT_MEM (SHORT_MEM),
        .BLK_LEN   (BLK_LEN)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .cfg_live (cfg_live),
        .cfg_eff  (cfg_eff),
        .fire     (fire),
        .first    (first),
        .last     (last),
        .tail     (tail),
        .in_ready (in_ready)
    );

    rsc_step #(
        .MEM       (MEM),
        .SHORT_MEM (SHORT_MEM)
    ) u_step (
        .state      (state_eff),
        .cfg        (cfg_eff),
        .in_bit     (in_bit),
        .tail       (tail),
        .res        (res),
        .next_state (state_nxt)
    );

    // Encoder register, advanced on every step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (fire) begin
            state_q <= state_nxt;
        end
    end

    // Output register for the coded pair, markers and end check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sys   <= 1'b0;
            out_par   <= 1'b0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            term_err  <= 1'b0;
        end else begin
            out_valid <= fire;
            out_sys   <= res.sys;
            out_par   <= res.par;
            out_first <= fire && first;
            out_last  <= fire && last;
            term_err  <= fire && last && (state_nxt != '0);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1
    AST_SYS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_sys == $past(in_bit))); // R3
    AST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> !term_err); // R5
    AST_ERR_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        term_err |-> out_last); // R9
endmodule

// File: tb/rsc_term_enc_test.sv
// Self-checking bench: random and directed bits, configuration changes,
// compared each falling edge against a bench-side shift-register model.
module rsc_term_enc_test;
    localparam int BLK = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_short = 1'b0;
    logic [3:0] cfg_fb_taps = 4'b1111;
    logic [3:0] cfg_ff_taps = 4'b1000;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_ready, out_valid, out_sys, out_par, out_first, out_last, term_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    logic [3:0] m_st = '0;
    int         m_cnt = 0;
    logic       m_short = 0;
    logic [3:0] m_fb = '0, m_ff = '0;
    logic       e_valid = 0, e_sys = 0, e_par = 0, e_first = 0, e_last = 0, e_err = 0;
    int         blocks_done = 0;

    rsc_term_enc #(.BLK_LEN(BLK)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_short(cfg_short),
        .cfg_fb_taps(cfg_fb_taps), .cfg_ff_taps(cfg_ff_taps),
        .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
        .out_valid(out_valid), .out_sys(out_sys), .out_par(out_par),
        .out_first(out_first), .out_last(out_last), .term_err(term_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mem_of(input logic s);
        return s ? 2 : 4;
    endfunction

    function automatic logic model_ready();
        return !(m_cnt != 0 && m_cnt >= BLK - mem_of(m_short));
    endfunction

    // Model one step for the inputs now driven; sets expected outputs.
    task automatic model_step();
        logic [3:0] mask, fbt, fft, st, nxt;
        logic       tl, u, a, fs;
        bit         fire;
        tl   = !model_ready();
        fire = tl || in_valid;
        e_valid = fire;
        if (!fire) return;
        if (m_cnt == 0) begin
            m_short = cfg_short; m_fb = cfg_fb_taps; m_ff = cfg_ff_taps;
            st = '0;
        end else st = m_st;
        mask = m_short ? 4'b0011 : 4'b1111;
        fbt = m_fb & mask;
        fft = m_ff & mask;
        fs  = ^(st & fbt);
        u   = tl ? fs : in_bit;
        a   = u ^ fs;
        nxt = {st[2:0], a} & mask;
        e_sys   = u;
        e_par   = a ^ (^(st & fft));
        e_first = (m_cnt == 0);
        e_last  = (m_cnt == BLK - 1);
        e_err   = e_last && (nxt != 0);
        m_st    = nxt;
        if (e_last) begin m_cnt = 0; blocks_done++; end
        else m_cnt++;
    endtask

    // Compare registered outputs with the step modelled one edge earlier.
    task automatic compare();
        chk(out_valid == e_valid, "R4/R8 out_valid", out_valid, e_valid);
        if (e_valid) begin
            chk(out_sys == e_sys, "R3/R5 out_sys", out_sys, e_sys);
            chk(out_par == e_par, "R2/R6/R7 out_par", out_par, e_par);
            chk(out_first == e_first, "R4 out_first", out_first, e_first);
            chk(out_last == e_last, "R4 out_last", out_last, e_last);
            chk(term_err == e_err, "R5/R9 term_err", term_err, e_err);
        end else begin
            chk(term_err == 1'b0, "R9 term_err idle", term_err, 1'b0);
        end
    endtask

    // mode: 0 random, 1 all ones full rate, 2 all zeros, 3 alternating
    task automatic run(input int n, input int mode, input int vpct, input bit cfg_rand);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            in_valid = ($urandom % 100) < vpct;
            case (mode)
                1: in_bit = 1'b1;
                2: in_bit = 1'b0;
                3: in_bit = i[0];
                default: in_bit = $urandom % 2;
            endcase
            if (cfg_rand && ($urandom % 13) == 0) begin
                cfg_short   = $urandom % 2;
                cfg_fb_taps = $urandom % 16;
                cfg_ff_taps = $urandom % 16;
            end
            chk(in_ready == model_ready(), "R5 in_ready", in_ready, model_ready());
            model_step();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 1'b0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 1'b0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1'b1);
        chk(out_first == 1'b0, "R1 out_first after reset", out_first, 1'b0);
        // directed: 16-state 37/21, full rate all ones across blocks
        run(3 * BLK, 1, 100, 0);
        // directed: idle gaps (R8) with alternating bits
        run(2 * BLK, 3, 30, 0);
        // directed: 4-state 7/5 with junk in upper tap bits (R6)
        cfg_short = 1; cfg_fb_taps = 4'b1111; cfg_ff_taps = 4'b1110;
        run(3 * BLK, 0, 100, 0);
        // zeros, back to 16-state
        cfg_short = 0; cfg_fb_taps = 4'b1111; cfg_ff_taps = 4'b1000;
        run(2 * BLK, 2, 80, 0);
        // random bits, random gaps, configuration changing mid-block (R7)
        run(6000, 0, 60, 1);
        @(negedge clk);
        compare();
        chk(blocks_done > 20, "R4 blocks completed", blocks_done > 20, 1'b1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R4 actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule